// File: doc/BRIEF.md
# Compliance Load Board Sequencer

This block is the execution-mode controller a retimer runs when one of its two pseudo ports sits in front of a passive compliance load and the other keeps receiving training traffic. While the retimer forwards at the base rate (2.5 GT/s), a detector watches each port. A port arms after a long run of training sets that carry PAD link and lane numbers, as long as the opposite port stays quiet. It triggers when a compliance pattern arrives, or when an EIOS is followed by a short idle gap and then an idle exit that cannot be forwarded. The port that triggers becomes port A. The opposite port, port B, drives the load.

After a trigger the sequencer takes over both transmitters. It has port B probe for receivers. It then plays a compliance pattern out of port B, choosing a new pattern setting on every entry and changing rate first where the setting calls for it. An idle exit seen by port B ends the pattern. Port A then replays that exit towards its partner on the same lanes, port B closes its transmitter, and both ports go back to forwarding at the base rate. The pattern generators, the receiver-detect circuit and the idle-exit detectors are outside the block. It receives their results as decoded events and drives their enables.

All time intervals are counted in clock cycles. `MS_CYC` gives the number of cycles in one millisecond.

Top module: `cmpl_lb_seq`

## Requirements
- R1: No entry into execution mode happens while `fwd_base_rate` is low, whatever the other inputs do.
- R2: A port arms once `rx_ts1_pad` for that port has been high for at least 5 ms of cycles while the opposite port's `rx_exit_any` stayed low. A pulse on the opposite `rx_exit_any` restarts the window. Once armed, a pulse on that port's `rx_cpat` raises `exec_mode` on the next clock. `exec_mode` stays low if the window was shorter.
- R3: On an armed port, an `rx_eios` pulse followed within 5 ms by an `rx_exit_unfwd` pulse also triggers entry. An `rx_exit_unfwd` that arrives more than 5 ms after the EIOS does not.
- R4: In the entry state `rxdet_req` and `link_up_clr` are high, and so are `rx_ignore`, `a_hold_idle` and `b_hold_idle`. `rate_code` is 0 and no pattern lane is enabled. `exec_mode` and all enables are low after reset.
- R5: If `rxdet_found` is all zero when `rxdet_done` arrives, no compliance lane is ever enabled and no exit-pattern lane is driven. `exec_mode` falls 1 ms after the detect result.
- R6: In the pattern state `cpat_lane_en` equals the lanes that detected a receiver, `b_hold_idle` is low and port A is held idle.
- R7: `cpat_setting` takes the values 0, 1, 2, … on successive entries, and wraps to 0 after `NUM_SET-1` (default 36).
- R8: If `rx_ts_seen` has pulsed on the port that becomes port B at any time since reset, a counter value of `LATE_SET` (default 26) or more is replaced by setting 0. Counting then continues from 1.
- R9: Setting-to-rate map, given as `rate_code` values: settings 0–1 use 0 (2.5 GT/s), 2–4 use 1 (5 GT/s), 5–11 use 2 (8 GT/s), 12–25 use 3 (16 GT/s), and 26 and up use 4 (32 GT/s). A nonzero code is preceded by 1.5 ms of idle (more than 1 ms, at most 2 ms). The new rate appears in the same cycle the pattern starts.
- R10: Exits reported by `b_lane_exit` on lanes with no detected receiver leave the pattern running. An exit on a detected lane moves the sequencer to the exit state on the next clock.
- R11: In the exit state `a_exit_pat_lane` equals the detected lanes that reported the exit, for exactly 1 ms.
- R12: If `rate_code` is nonzero at that point, `b_send_eios` stays high until eight `b_os_sent` pulses have arrived. Port B is then held idle for 1 ms, after which `exec_mode` falls with `rate_code` back at 0. At rate 0, `exec_mode` falls right after the exit pattern ends.
- R13: `a_port` reports which physical port triggered entry. If both trigger in the same cycle, port 0 wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fwd_base_rate | input | 1 | Retimer is forwarding at 2.5 GT/s |
| rx_ts1_pad | input | 2 | Per port: some lane receives TS1 with PAD link/lane numbers |
| rx_exit_any | input | 2 | Per port: idle exit seen on some lane |
| rx_cpat | input | 2 | Per port: compliance pattern received (pulse) |
| rx_eios | input | 2 | Per port: EIOS received (pulse) |
| rx_exit_unfwd | input | 2 | Per port: idle exit that cannot be forwarded (pulse) |
| rx_ts_seen | input | 2 | Per port: TS1/TS2 or complement received (pulse) |
| rxdet_done | input | 1 | Port B receiver detection finished (pulse) |
| rxdet_found | input | LANES | Port B lanes with a receiver, valid with rxdet_done |
| b_lane_exit | input | LANES | Port B per-lane idle exit |
| b_os_sent | input | 1 | Port B finished sending one EIOS (pulse) |
| exec_mode | output | 1 | Sequencer owns the transmitters |
| a_port | output | 1 | Physical index of port A |
| link_up_clr | output | 1 | Clear the link-up flag |
| rx_ignore | output | 1 | Receivers ignore incoming data |
| rxdet_req | output | 1 | Request receiver detection on port B |
| a_hold_idle | output | 1 | Force port A transmitter idle |
| b_hold_idle | output | 1 | Force port B transmitter idle |
| rate_code | output | 3 | Data rate for both ports (0 = 2.5 GT/s … 4 = 32 GT/s) |
| cpat_lane_en | output | LANES | Port B lanes sending the compliance pattern |
| cpat_setting | output | $clog2(NUM_SET) | Compliance pattern setting in use |
| a_exit_pat_lane | output | LANES | Port A lanes sending the idle-exit pattern |
| b_send_eios | output | 1 | Port B sends EIOS |

## Verification
The hardest state to reach from the ports is the high end of the setting sequence. That includes the wrap after the last setting and the substitution of setting 0 once port B has seen training traffic. Both appear only after dozens of complete entry-to-forwarding round trips. The bench scales a millisecond down to a few tens of cycles and drives entries in a loop with random trigger port, trigger kind, detected lanes and exit lanes. It then steers the trigger port directly, so the counter lands on the late threshold with each possible port B history.

// File: rtl/cmpl_lb_pkg.sv
package cmpl_lb_pkg;

   typedef enum logic [2:0] {
      ST_FWD,
      ST_ENTRY,
      ST_RATE_HOLD,
      ST_PATTERN,
      ST_EXIT_A,
      ST_EXIT_EIOS,
      ST_EXIT_IDLE
   } lb_state_e;

   localparam int unsigned RATE_W        = 3;
   localparam int unsigned EIOS_COUNT    = 8;
   // first setting index of each faster rate
   localparam int unsigned FIRST_5G      = 2;
   localparam int unsigned FIRST_8G      = 5;
   localparam int unsigned FIRST_16G     = 12;
   localparam int unsigned FIRST_32G     = 26;

   function automatic logic [RATE_W-1:0] setting_rate(input int unsigned s);
      if (s < FIRST_5G)       return RATE_W'(0);
      else if (s < FIRST_8G)  return RATE_W'(1);
      else if (s < FIRST_16G) return RATE_W'(2);
      else if (s < FIRST_32G) return RATE_W'(3);
      else                    return RATE_W'(4);
   endfunction

endpackage

// File: rtl/cmpl_lb_entry_det.sv
module cmpl_lb_entry_det #(
   parameter int unsigned WIN_CYC  = 500,
   parameter int unsigned IDLE_CYC = 500,
   localparam int unsigned MAXC    = (WIN_CYC > IDLE_CYC) ? WIN_CYC : IDLE_CYC,
   localparam int unsigned CW      = $clog2(MAXC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ts1_pad,
   input  logic other_exit,
   input  logic eios,
   input  logic cpat,
   input  logic unfwd,
   output logic trig
);

   if (WIN_CYC < 2)  begin : g_bad_win  $error("WIN_CYC must be at least 2");  end
   if (IDLE_CYC < 2) begin : g_bad_idle $error("IDLE_CYC must be at least 2"); end

   logic [CW-1:0] win_cnt;
   logic [CW-1:0] idle_cnt;
   logic          armed;
   logic          idle_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt  <= '0;
         idle_cnt <= '0;
         armed    <= 1'b0;
         idle_run <= 1'b0;
      end else if (!en) begin
         win_cnt  <= '0;
         idle_cnt <= '0;
         armed    <= 1'b0;
         idle_run <= 1'b0;
      end else begin
         // qualifying window of PAD training sets
         if (!ts1_pad || other_exit)
            win_cnt <= '0;
         else if (win_cnt != CW'(WIN_CYC))
            win_cnt <= win_cnt + 1'b1;

         if (other_exit)
            armed <= 1'b0;
         else if (ts1_pad && win_cnt == CW'(WIN_CYC - 1))
            armed <= 1'b1;

         // bounded idle gap after an EIOS
         if (other_exit) begin
            idle_run <= 1'b0;
         end else if (armed && eios) begin
            idle_run <= 1'b1;
            idle_cnt <= '0;
         end else if (idle_run) begin
            if (idle_cnt == CW'(IDLE_CYC - 1))
               idle_run <= 1'b0;
            idle_cnt <= idle_cnt + 1'b1;
         end
      end
   end

   assign trig = en && armed && (cpat || (idle_run && unfwd));

endmodule

// File: rtl/cmpl_lb_setting.sv
module cmpl_lb_setting #(
   parameter int unsigned NUM_SET  = 37,
   parameter int unsigned LATE_SET = 26,
   localparam int unsigned SW      = $clog2(NUM_SET)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          b_ts_seen,
   output logic [SW-1:0] sel
);

   if (NUM_SET < 2)         begin : g_bad_num  $error("NUM_SET must be at least 2");        end
   if (LATE_SET >= NUM_SET) begin : g_bad_late $error("LATE_SET must be below NUM_SET");    end

   logic [SW-1:0] cnt;

   assign sel = (b_ts_seen && cnt >= SW'(LATE_SET)) ? '0 : cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (take)
         cnt <= (sel == SW'(NUM_SET - 1)) ? '0 : sel + 1'b1;
   end

endmodule

// File: rtl/cmpl_lb_seq.sv
module cmpl_lb_seq
   import cmpl_lb_pkg::*;
#(
   parameter int unsigned LANES    = 4,
   parameter int unsigned MS_CYC   = 125000,
   parameter int unsigned NUM_SET  = 37,
   parameter int unsigned LATE_SET = 26,
   localparam int unsigned SW      = $clog2(NUM_SET),
   localparam int unsigned WIN_CYC = 5 * MS_CYC,
   localparam int unsigned HOLD_CYC = MS_CYC + MS_CYC / 2,
   localparam int unsigned TW      = $clog2(2 * MS_CYC + 1),
   localparam int unsigned EW      = $clog2(EIOS_COUNT + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fwd_base_rate,
   input  logic [1:0]           rx_ts1_pad,
   input  logic [1:0]           rx_exit_any,
   input  logic [1:0]           rx_cpat,
   input  logic [1:0]           rx_eios,
   input  logic [1:0]           rx_exit_unfwd,
   input  logic [1:0]           rx_ts_seen,
   input  logic                 rxdet_done,
   input  logic [LANES-1:0]     rxdet_found,
   input  logic [LANES-1:0]     b_lane_exit,
   input  logic                 b_os_sent,
   output logic                 exec_mode,
   output logic                 a_port,
   output logic                 link_up_clr,
   output logic                 rx_ignore,
   output logic                 rxdet_req,
   output logic                 a_hold_idle,
   output logic                 b_hold_idle,
   output logic [RATE_W-1:0]    rate_code,
   output logic [LANES-1:0]     cpat_lane_en,
   output logic [SW-1:0]        cpat_setting,
   output logic [LANES-1:0]     a_exit_pat_lane,
   output logic                 b_send_eios
);

   if (LANES < 1)  begin : g_bad_lanes $error("LANES must be at least 1"); end
   if (MS_CYC < 2) begin : g_bad_ms    $error("MS_CYC must be at least 2"); end

   lb_state_e           state_q, state_d;
   logic [TW-1:0]       tmr;
   logic [EW-1:0]       eios_cnt;
   logic [RATE_W-1:0]   rate_q;
   logic [LANES-1:0]    det_q;
   logic [LANES-1:0]    exit_q;
   logic [SW-1:0]       sel_q;
   logic [SW-1:0]       sel_now;
   logic                a_port_q;
   logic [1:0]          seen_q;
   logic [1:0]          trig;
   logic                take;
   logic                win_port;
   logic                b_seen_now;
   logic                det_en;
   logic [LANES-1:0]    hit;

   assign det_en = (state_q == ST_FWD) && fwd_base_rate;

   for (genvar p = 0; p < 2; p++) begin : g_det
      cmpl_lb_entry_det #(
         .WIN_CYC  (WIN_CYC),
         .IDLE_CYC (WIN_CYC)
      ) u_det (
         .clk        (clk),
         .rst_n      (rst_n),
         .en         (det_en),
         .ts1_pad    (rx_ts1_pad[p]),
         .other_exit (rx_exit_any[1-p]),
         .eios       (rx_eios[p]),
         .cpat       (rx_cpat[p]),
         .unfwd      (rx_exit_unfwd[p]),
         .trig       (trig[p])
      );
   end

   assign take       = (state_q == ST_FWD) && (trig != 2'b00);
   assign win_port   = !trig[0];
   assign b_seen_now = win_port ? seen_q[0] : seen_q[1];

   cmpl_lb_setting #(
      .NUM_SET  (NUM_SET),
      .LATE_SET (LATE_SET)
   ) u_setting (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .b_ts_seen (b_seen_now),
      .sel       (sel_now)
   );

   assign hit = b_lane_exit & det_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_FWD:
            if (take) state_d = ST_ENTRY;
         ST_ENTRY:
            if (rxdet_done) begin
               if (rxdet_found == '0)
                  state_d = ST_EXIT_A;
               else if (setting_rate(32'(sel_q)) != '0)
                  state_d = ST_RATE_HOLD;
               else
                  state_d = ST_PATTERN;
            end
         ST_RATE_HOLD:
            if (tmr == TW'(HOLD_CYC - 1)) state_d = ST_PATTERN;
         ST_PATTERN:
            if (hit != '0) state_d = ST_EXIT_A;
         ST_EXIT_A:
            if (tmr == TW'(MS_CYC - 1))
               state_d = (rate_q != '0) ? ST_EXIT_EIOS : ST_FWD;
         ST_EXIT_EIOS:
            if (b_os_sent && eios_cnt == EW'(EIOS_COUNT - 1)) state_d = ST_EXIT_IDLE;
         ST_EXIT_IDLE:
            if (tmr == TW'(MS_CYC - 1)) state_d = ST_FWD;
         default:
            state_d = ST_FWD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_FWD;
         tmr      <= '0;
         eios_cnt <= '0;
         rate_q   <= '0;
         det_q    <= '0;
         exit_q   <= '0;
         sel_q    <= '0;
         a_port_q <= 1'b0;
         seen_q   <= '0;
      end else begin
         state_q <= state_d;
         seen_q  <= seen_q | rx_ts_seen;

         if (state_q == ST_FWD || state_d != state_q)
            tmr <= '0;
         else
            tmr <= tmr + 1'b1;

         if (state_q != ST_EXIT_EIOS)
            eios_cnt <= '0;
         else if (b_os_sent)
            eios_cnt <= eios_cnt + 1'b1;

         if (take) begin
            a_port_q <= win_port;
            sel_q    <= sel_now;
         end

         if (state_q == ST_ENTRY && rxdet_done) begin
            det_q  <= rxdet_found;
            exit_q <= '0;
         end

         if (state_q == ST_PATTERN && hit != '0)
            exit_q <= hit;

         if (state_q == ST_RATE_HOLD && state_d == ST_PATTERN)
            rate_q <= setting_rate(32'(sel_q));
         else if (state_q == ST_EXIT_IDLE && state_d == ST_FWD)
            rate_q <= '0;
      end
   end

   assign exec_mode       = (state_q != ST_FWD);
   assign a_port          = a_port_q;
   assign link_up_clr     = (state_q == ST_ENTRY);
   assign rxdet_req       = (state_q == ST_ENTRY);
   assign rx_ignore       = exec_mode;
   assign a_hold_idle     = exec_mode && (state_q != ST_EXIT_A);
   assign b_hold_idle     = exec_mode && (state_q != ST_PATTERN) && (state_q != ST_EXIT_EIOS);
   assign rate_code       = rate_q;
   assign cpat_lane_en    = (state_q == ST_PATTERN) ? det_q : '0;
   assign cpat_setting    = sel_q;
   assign a_exit_pat_lane = (state_q == ST_EXIT_A) ? exit_q : '0;
   assign b_send_eios     = (state_q == ST_EXIT_EIOS);

endmodule

// File: rtl/cmpl_lb_seq_chk.sv
module cmpl_lb_seq_chk #(
   parameter int unsigned LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fwd_base_rate,
   input logic             exec_mode,
   input logic             rxdet_req,
   input logic             link_up_clr,
   input logic             rx_ignore,
   input logic             a_hold_idle,
   input logic             b_hold_idle,
   input logic [2:0]       rate_code,
   input logic [LANES-1:0] cpat_lane_en,
   input logic [LANES-1:0] a_exit_pat_lane,
   input logic             b_send_eios
);

   // R1: entering execution requires base-rate forwarding one cycle earlier
   a_r1_entry_base_rate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exec_mode) |-> $past(fwd_base_rate));

   // R4: entry state keeps everything quiet at base rate
   a_r4_entry_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rxdet_req |-> (rate_code == 3'd0 && a_hold_idle && b_hold_idle && rx_ignore
                     && link_up_clr && cpat_lane_en == '0 && a_exit_pat_lane == '0));

   // R6: port A idle while port B plays the pattern
   a_r6_pattern_a_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cpat_lane_en != '0) |-> (a_hold_idle && !b_hold_idle && a_exit_pat_lane == '0));

   // R9: a step to a faster rate coincides with the start of the pattern
   a_r9_rate_step: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_mode && $past(exec_mode) && rate_code != $past(rate_code) && rate_code != 3'd0)
      |-> (cpat_lane_en != '0));

   // R11: exit pattern on port A only while port B is held idle
   a_r11_exit_b_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (a_exit_pat_lane != '0) |-> (b_hold_idle && !a_hold_idle && cpat_lane_en == '0));

   // R12: EIOS only above the base rate
   a_r12_eios_rate: assert property (@(posedge clk) disable iff (!rst_n)
      b_send_eios |-> (rate_code != 3'd0 && a_hold_idle));

   // R12: forwarding resumes at base rate
   a_r12_back_base: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(exec_mode) |-> (rate_code == 3'd0));

   // R4: outside execution the block forces nothing
   a_r4_fwd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_mode |-> (!a_hold_idle && !b_hold_idle && !rxdet_req && !b_send_eios
                      && cpat_lane_en == '0 && a_exit_pat_lane == '0 && rate_code == 3'd0));

endmodule

bind cmpl_lb_seq cmpl_lb_seq_chk #(.LANES(LANES)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .fwd_base_rate   (fwd_base_rate),
   .exec_mode       (exec_mode),
   .rxdet_req       (rxdet_req),
   .link_up_clr     (link_up_clr),
   .rx_ignore       (rx_ignore),
   .a_hold_idle     (a_hold_idle),
   .b_hold_idle     (b_hold_idle),
   .rate_code       (rate_code),
   .cpat_lane_en    (cpat_lane_en),
   .a_exit_pat_lane (a_exit_pat_lane),
   .b_send_eios     (b_send_eios)
);

// File: tb/cmpl_lb_seq_tb.sv
module cmpl_lb_seq_tb;

   localparam int L    = 4;
   localparam int MS   = 20;
   localparam int WIN  = 5 * MS;
   localparam int NSET = 37;
   localparam int LATE = 26;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         fwd_base_rate = 1'b1;
   logic [1:0]   rx_ts1_pad = '0, rx_exit_any = '0, rx_cpat = '0;
   logic [1:0]   rx_eios = '0, rx_exit_unfwd = '0, rx_ts_seen = '0;
   logic         rxdet_done = 1'b0;
   logic [L-1:0] rxdet_found = '0, b_lane_exit = '0;
   logic         b_os_sent = 1'b0;
   logic         exec_mode, a_port, link_up_clr, rx_ignore, rxdet_req;
   logic         a_hold_idle, b_hold_idle, b_send_eios;
   logic [2:0]   rate_code;
   logic [L-1:0] cpat_lane_en, a_exit_pat_lane;
   logic [5:0]   cpat_setting;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int m_cnt = 0;
   bit m_seen [2] = '{0, 0};

   always #4 clk = ~clk;

   cmpl_lb_seq #(.LANES(L), .MS_CYC(MS), .NUM_SET(NSET), .LATE_SET(LATE)) u_dut (.*);

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int exp_rate(input int s);
      if (s < 2) return 0;
      if (s < 5) return 1;
      if (s < 12) return 2;
      if (s < 26) return 3;
      return 4;
   endfunction

   function automatic int exp_sel(input int ap);
      return (m_cnt >= LATE && m_seen[1-ap]) ? 0 : m_cnt;
   endfunction

   // one full round trip: arm, trigger, detect, pattern, exit, back to forwarding
   task automatic run_entry(input int ap, input bit both, input logic [L-1:0] found,
                            input logic [L-1:0] extra, input bit via_seq);
      int es, cnt;
      bit bad;
      logic [L-1:0] hit;
      if (both) rx_ts1_pad = 2'b11; else rx_ts1_pad[ap] = 1'b1;
      tick(WIN + 3);
      rx_ts1_pad = '0;
      if (via_seq) begin
         rx_eios[ap] = 1'b1; tick(1); rx_eios[ap] = 1'b0;
         tick(5);
         rx_exit_unfwd[ap] = 1'b1; tick(1); rx_exit_unfwd[ap] = 1'b0;
      end else begin
         if (both) rx_cpat = 2'b11; else rx_cpat[ap] = 1'b1;
         tick(1);
         rx_cpat = '0;
      end
      es = exp_sel(ap);
      chk(exec_mode == 1'b1, via_seq ? "R3 entry" : "R2 entry", exec_mode, 1);
      chk(a_port == ap[0], "R13 port A", a_port, ap);
      chk(cpat_setting == es, "R7 setting", cpat_setting, es);
      chk(rxdet_req && link_up_clr && rx_ignore && a_hold_idle && b_hold_idle && rate_code == 0,
          "R4 entry outputs", {rxdet_req, link_up_clr, rx_ignore, a_hold_idle, b_hold_idle}, 5'h1f);
      m_cnt = (es == NSET - 1) ? 0 : es + 1;
      tick(2);
      rxdet_found = found; rxdet_done = 1'b1; tick(1); rxdet_done = 1'b0;
      if (found == '0) begin
         cnt = 1; bad = 0;
         while (exec_mode && cnt < 1000) begin
            if (cpat_lane_en != '0 || a_exit_pat_lane != '0) bad = 1;
            tick(1); cnt++;
         end
         chk(!bad, "R5 no lanes driven", bad, 0);
         chk(cnt == MS + 1, "R5 exit time", cnt, MS + 1);
         return;
      end
      cnt = 1;
      while (cpat_lane_en == '0 && cnt < 1000) begin tick(1); cnt++; end
      if (exp_rate(es) == 0)
         chk(cnt == 1, "R9 no hold", cnt, 1);
      else
         chk(cnt - 1 > MS && cnt - 1 <= 2 * MS, "R9 hold length", cnt - 1, MS + MS / 2);
      chk(cpat_lane_en == found, "R6 pattern lanes", cpat_lane_en, found);
      chk(rate_code == exp_rate(es), "R9 rate", rate_code, exp_rate(es));
      chk(a_hold_idle && !b_hold_idle, "R6 port A idle", {a_hold_idle, b_hold_idle}, 2'b10);
      if (~found != '0) begin
         b_lane_exit = ~found; tick(2); b_lane_exit = '0;
         chk(cpat_lane_en == found, "R10 undetected exit ignored", cpat_lane_en, found);
      end
      hit = found & extra;
      if (hit == '0) hit = found & (~found + 1'b1);
      b_lane_exit = hit | ~found; tick(1); b_lane_exit = '0;
      chk(cpat_lane_en == '0, "R10 pattern stops", cpat_lane_en, 0);
      cnt = 0; bad = 0;
      while (a_exit_pat_lane != '0 && cnt < 1000) begin
         if (a_exit_pat_lane != hit) bad = 1;
         tick(1); cnt++;
      end
      chk(!bad, "R11 exit lanes", bad, 0);
      chk(cnt == MS, "R11 exit length", cnt, MS);
      if (exp_rate(es) == 0) begin
         chk(exec_mode == 1'b0, "R12 back at base", exec_mode, 0);
         return;
      end
      chk(b_send_eios == 1'b1, "R12 EIOS start", b_send_eios, 1);
      for (int i = 0; i < 8; i++) begin
         b_os_sent = 1'b1; tick(1); b_os_sent = 1'b0;
         if (i < 7) begin
            chk(b_send_eios == 1'b1, "R12 EIOS count", b_send_eios, 1);
            tick(1);
         end
      end
      chk(!b_send_eios && exec_mode && b_hold_idle, "R12 idle after EIOS", b_send_eios, 0);
      cnt = 0;
      while (exec_mode && cnt < 1000) begin tick(1); cnt++; end
      chk(cnt == MS, "R12 idle length", cnt, MS);
      chk(rate_code == 0, "R12 rate restored", rate_code, 0);
   endtask

   initial begin
      int unsigned seed_set;
      seed_set = $urandom(32'd4711);
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // reset state
      chk(!exec_mode && rate_code == 0 && cpat_lane_en == '0 && !rxdet_req,
          "R4 reset state", exec_mode, 0);

      // window too short
      rx_ts1_pad[0] = 1'b1; tick(WIN - 10); rx_ts1_pad = '0;
      rx_cpat[0] = 1'b1; tick(1); rx_cpat = '0; tick(2);
      chk(exec_mode == 1'b0, "R2 short window", exec_mode, 0);

      // opposite port exit restarts the window
      rx_ts1_pad[0] = 1'b1; tick(WIN / 2);
      rx_exit_any[1] = 1'b1; tick(1); rx_exit_any[1] = 1'b0;
      tick(WIN / 2 + 3); rx_ts1_pad = '0;
      rx_cpat[0] = 1'b1; tick(1); rx_cpat = '0; tick(2);
      chk(exec_mode == 1'b0, "R2 other exit", exec_mode, 0);

      // not at base rate
      fwd_base_rate = 1'b0;
      rx_ts1_pad[1] = 1'b1; tick(WIN + 3); rx_ts1_pad = '0;
      rx_cpat[1] = 1'b1; tick(1); rx_cpat = '0; tick(2);
      chk(exec_mode == 1'b0, "R1 non-base rate", exec_mode, 0);
      fwd_base_rate = 1'b1;

      // late unforwardable exit after EIOS
      rx_ts1_pad[1] = 1'b1; tick(WIN + 3); rx_ts1_pad = '0;
      rx_eios[1] = 1'b1; tick(1); rx_eios[1] = 1'b0;
      tick(WIN + 10);
      rx_exit_unfwd[1] = 1'b1; tick(1); rx_exit_unfwd[1] = 1'b0; tick(2);
      chk(exec_mode == 1'b0, "R3 late exit", exec_mode, 0);
      tick(2);

      run_entry(0, 0, 4'b0000, 4'b0000, 0);     // R5 no receivers
      run_entry(1, 0, 4'b0110, 4'b0100, 1);     // R3 sequence path
      run_entry(0, 1, 4'b1011, 4'b1000, 0);     // R13 tie goes to port 0

      // random round trips through the wrap (R7)
      for (int i = 0; i < 40; i++)
         run_entry($urandom % 2, 0, L'($urandom), L'($urandom), bit'($urandom % 2));

      // port 1 has seen training traffic (R8)
      rx_ts_seen[1] = 1'b1; tick(1); rx_ts_seen = '0; m_seen[1] = 1;
      while (m_cnt != LATE)
         run_entry(1, 0, L'($urandom) | 4'b0001, L'($urandom), 0);
      run_entry(1, 0, 4'b1111, 4'b0010, 0);     // B = port 0: late setting kept
      while (m_cnt != LATE)
         run_entry(1, 0, L'($urandom) | 4'b0001, L'($urandom), 1);
      chk(exp_sel(0) == 0, "R8 model skip", exp_sel(0), 0);
      run_entry(0, 0, 4'b0101, 4'b0001, 0);     // B = port 1: skipped to 0

      summary();
      $finish;
   end

endmodule